// File: doc/BRIEF.md
# Parallel Printer Port Host Register Interface

This block is the processor-side register set of a PC-style parallel printer port. A synchronous host bus reaches three byte registers by offset: an output data latch, a read-only status view of the printer's sense lines, and a control register. The control register drives the printer's handshake lines, each with a fixed polarity, and also holds an interrupt enable and a direction bit that tristates the eight data pins.

A 3-bit port mode sets how the data offset and the direction bit behave. In the compatible and byte modes, a data write loads the output latch. In the address-push mode, the same write sends the byte, tagged as an address/run-length byte, to an outbound FIFO port. The push happens only while the effective direction is outward. The acknowledge sense line is synchronised, and its rising edge raises a level interrupt when the enable bit is set.

Top module: `prnPortRegs`

## Requirements
- R1: After reset the data latch and control bits 5..0 are zero. Therefore pinDataOut is 0x00, ctlStrobeN, ctlAutoFdN and ctlSelInN are 1, ctlInitN is 0, pinDataOe is 1, ackIrq is 0 and busRdata is 0x00.
- R2: A write to offset 0 loads busWdata into the data latch only in modes 3'b000 and 3'b001. The latch is driven unchanged on pinDataOut. In every other mode the write leaves the latch unchanged.
- R3: A read of offset 0 returns the levels present on pinDataIn, not the latch. The value appears on busRdata in the cycle after busRd is sampled.
- R4: A read of offset 1 returns {~prnBusy, prnAckN, prnPaperErr, prnSelect, prnFaultN, 3'b000}, from bit 7 down to bit 0.
- R5: Offset 2 reads back control bits 5..0 as written. Bits 7..6 always read 0, and writes to them are ignored.
- R6: Control bit 0 drives ctlStrobeN inverted, bit 1 drives ctlAutoFdN inverted, bit 3 drives ctlSelInN inverted, and bit 2 drives ctlInitN unchanged.
- R7: In modes 3'b000 and 3'b010, pinDataOe is always 1. In all other modes, pinDataOe is the inverse of control bit 5 (1 = pins driven).
- R8: In mode 3'b011, with control bit 5 at 0 and fifoReady high, a write to offset 0 raises fifoValid in that same cycle. fifoData then equals busWdata and fifoTag is 1. With control bit 5 at 1, no push occurs.
- R9: With control bit 4 set, a low-to-high transition on prnAckN sets ackIrq SYNC_STAGES+1 clock edges later (3 with the default). With bit 4 clear, the edge sets nothing.
- R10: ackIrq is cleared by a read of offset 1 or by control bit 4 being 0. A new acknowledge edge in the same cycle wins over the clear.
- R11: A read of an offset other than 0, 1 or 2 returns 0x00. In a cycle after one with no read, busRdata is 0x00.
- R12: An address push attempted while fifoReady is low is dropped. fifoValid stays low during that write and afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portMode | input | 3 | Port mode selector |
| busAddr | input | ADDR_W | Register offset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, one-cycle latency |
| pinDataIn | input | 8 | Sampled levels of the data pins |
| pinDataOut | output | 8 | Data latch driven to pins |
| pinDataOe | output | 1 | Data pin output enable |
| prnFaultN | input | 1 | Printer fault sense (active low) |
| prnSelect | input | 1 | Printer selected sense |
| prnPaperErr | input | 1 | Paper error sense |
| prnAckN | input | 1 | Acknowledge sense (active low) |
| prnBusy | input | 1 | Busy sense |
| ctlStrobeN | output | 1 | Strobe line |
| ctlAutoFdN | output | 1 | Auto line feed line |
| ctlInitN | output | 1 | Initialise line |
| ctlSelInN | output | 1 | Select-in line |
| ackIrq | output | 1 | Acknowledge interrupt level |
| fifoValid | output | 1 | Address push strobe |
| fifoReady | input | 1 | FIFO can accept |
| fifoData | output | 8 | Pushed byte |
| fifoTag | output | 1 | Byte tag, 1 = address/run-length |

## Verification
A vector table walks one data write through each port mode, with the direction bit both set and clear. Each step uses a distinct write byte and a distinct pin pattern. This separates mode-gated latching from ignored writes, latch output from pin readback, and real pushes from pushes blocked by direction. Two complementary status input patterns show that every status bit lands in its own position with its own polarity. Acknowledge edges are applied with the enable on and off, and are followed by each of the two clear paths, to show the interrupt's latency and clearing.

// File: rtl/prnRegsPkg.sv
package prnRegsPkg;
  localparam int BYTE_W = 8;

  localparam logic [2:0] MODE_COMPAT = 3'b000;
  localparam logic [2:0] MODE_BYTE   = 3'b001;
  localparam logic [2:0] MODE_FIFO   = 3'b010;
  localparam logic [2:0] MODE_ADRPSH = 3'b011;

  localparam int OFS_DATA = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_CTRL = 2;

  typedef enum logic [1:0] {
    RSEL_NONE,
    RSEL_PINS,
    RSEL_STAT,
    RSEL_CTRL
  } rdSel_e;

  typedef struct packed {
    logic   wrData;
    logic   wrCtrl;
    logic   fifoPush;
    logic   statRead;
    rdSel_e rdSel;
  } regCmd_t;
endpackage

// File: rtl/prnCtrl.sv
module prnCtrl
  import prnRegsPkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [2:0]        portMode,
  input  logic              dirBit,
  input  logic              fifoReady,
  output regCmd_t           cmd,
  output logic              driveOut,
  output logic              fifoValid
);
  logic hitData, hitStat, hitCtrl;
  logic modeFixedOut, modeLatches;

  always_comb begin
    hitData      = (busAddr == ADDR_W'(OFS_DATA));
    hitStat      = (busAddr == ADDR_W'(OFS_STAT));
    hitCtrl      = (busAddr == ADDR_W'(OFS_CTRL));
    modeFixedOut = (portMode == MODE_COMPAT) || (portMode == MODE_FIFO);
    modeLatches  = (portMode == MODE_COMPAT) || (portMode == MODE_BYTE);
    driveOut     = modeFixedOut || !dirBit;

    cmd.wrData   = busWr && hitData && modeLatches;
    cmd.fifoPush = busWr && hitData && (portMode == MODE_ADRPSH) && driveOut;
    cmd.wrCtrl   = busWr && hitCtrl;
    cmd.statRead = busRd && hitStat;

    if (!busRd)       cmd.rdSel = RSEL_NONE;
    else if (hitData) cmd.rdSel = RSEL_PINS;
    else if (hitStat) cmd.rdSel = RSEL_STAT;
    else if (hitCtrl) cmd.rdSel = RSEL_CTRL;
    else              cmd.rdSel = RSEL_NONE;

    fifoValid = cmd.fifoPush && fifoReady;
  end
endmodule

// File: rtl/prnDatapath.sv
module prnDatapath
  import prnRegsPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  regCmd_t           cmd,
  input  logic [BYTE_W-1:0] busWdata,
  input  logic [BYTE_W-1:0] pinDataIn,
  input  logic              prnFaultN,
  input  logic              prnSelect,
  input  logic              prnPaperErr,
  input  logic              prnAckN,
  input  logic              prnBusy,
  output logic [BYTE_W-1:0] pinDataOut,
  output logic              dirBit,
  output logic [BYTE_W-1:0] busRdata,
  output logic              ctlStrobeN,
  output logic              ctlAutoFdN,
  output logic              ctlInitN,
  output logic              ctlSelInN,
  output logic              ackIrq
);
  localparam int CTL_W = 6;

  logic [BYTE_W-1:0]      dataReg;
  logic [CTL_W-1:0]       ctlReg;
  logic [SYNC_STAGES-1:0] ackSync;
  logic                   ackPrev;
  logic                   ackRise;
  logic [BYTE_W-1:0]      statusByte;

  // Output data latch
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           dataReg <= '0;
    else if (cmd.wrData) dataReg <= busWdata;
  end

  // Control register, only the low six bits exist
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           ctlReg <= '0;
    else if (cmd.wrCtrl) ctlReg <= busWdata[CTL_W-1:0];
  end

  // Acknowledge synchroniser chain
  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) ackSync[0] <= 1'b1;
          else       ackSync[0] <= prnAckN;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) ackSync[gi] <= 1'b1;
          else       ackSync[gi] <= ackSync[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ackPrev <= 1'b1;
    else       ackPrev <= ackSync[SYNC_STAGES-1];
  end

  assign ackRise = ackSync[SYNC_STAGES-1] && !ackPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            ackIrq <= 1'b0;
    else if (ackRise && ctlReg[4])        ackIrq <= 1'b1;
    else if (cmd.statRead || !ctlReg[4])  ackIrq <= 1'b0;
  end

  // Read path with one-cycle latency
  assign statusByte = {~prnBusy, prnAckN, prnPaperErr, prnSelect, prnFaultN, 3'b000};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else begin
      case (cmd.rdSel)
        RSEL_PINS: busRdata <= pinDataIn;
        RSEL_STAT: busRdata <= statusByte;
        RSEL_CTRL: busRdata <= {{(BYTE_W-CTL_W){1'b0}}, ctlReg};
        default:   busRdata <= '0;
      endcase
    end
  end

  // Printer line polarities
  assign pinDataOut = dataReg;
  assign dirBit     = ctlReg[5];
  assign ctlStrobeN = ~ctlReg[0];
  assign ctlAutoFdN = ~ctlReg[1];
  assign ctlInitN   =  ctlReg[2];
  assign ctlSelInN  = ~ctlReg[3];

  // R2: a mode-gated data write lands in the latch
  a_r2_data_capture: assert property (@(posedge clk) disable iff (!rstN)
    cmd.wrData |=> (pinDataOut == $past(busWdata)));

  // R8: an address push never disturbs the data latch
  a_r8_push_no_latch: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.fifoPush && !cmd.wrData) |=> $stable(pinDataOut));

  a_r5_ctrl_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdSel == RSEL_CTRL) |=> (busRdata[7:6] == 2'b00));

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackIrq) |-> $past(ctlReg[4]));

  a_r10_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (ackIrq && cmd.statRead && !ackRise) |=> !ackIrq);

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdSel == RSEL_NONE) |=> (busRdata == '0));
endmodule

// File: rtl/prnPortRegs.sv
module prnPortRegs
  import prnRegsPkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        portMode,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  output logic [7:0]        busRdata,
  input  logic [7:0]        pinDataIn,
  output logic [7:0]        pinDataOut,
  output logic              pinDataOe,
  input  logic              prnFaultN,
  input  logic              prnSelect,
  input  logic              prnPaperErr,
  input  logic              prnAckN,
  input  logic              prnBusy,
  output logic              ctlStrobeN,
  output logic              ctlAutoFdN,
  output logic              ctlInitN,
  output logic              ctlSelInN,
  output logic              ackIrq,
  output logic              fifoValid,
  input  logic              fifoReady,
  output logic [7:0]        fifoData,
  output logic              fifoTag
);
  regCmd_t cmd;
  logic    dirBit;

  prnCtrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .portMode (portMode),
    .dirBit   (dirBit),
    .fifoReady(fifoReady),
    .cmd      (cmd),
    .driveOut (pinDataOe),
    .fifoValid(fifoValid)
  );

  prnDatapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .busWdata   (busWdata),
    .pinDataIn  (pinDataIn),
    .prnFaultN  (prnFaultN),
    .prnSelect  (prnSelect),
    .prnPaperErr(prnPaperErr),
    .prnAckN    (prnAckN),
    .prnBusy    (prnBusy),
    .pinDataOut (pinDataOut),
    .dirBit     (dirBit),
    .busRdata   (busRdata),
    .ctlStrobeN (ctlStrobeN),
    .ctlAutoFdN (ctlAutoFdN),
    .ctlInitN   (ctlInitN),
    .ctlSelInN  (ctlSelInN),
    .ackIrq     (ackIrq)
  );

  assign fifoData = busWdata;
  assign fifoTag  = 1'b1;

  // R8: a push is only offered while the pins face outward
  a_r8_push_outward: assert property (@(posedge clk) disable iff (!rstN)
    fifoValid |-> pinDataOe);
endmodule

// File: tb/prnPortRegs_bench.sv
module prnPortRegs_bench;
  localparam int PERIOD = 10;
  localparam int NVEC   = 9;

  // {mode, ctl, wdata, pins, expOut, expOe, expPush}
  localparam logic [36:0] VEC [NVEC] = '{
    {3'b000, 8'h20, 8'hA5, 8'h3C, 8'hA5, 1'b1, 1'b0},
    {3'b001, 8'h00, 8'h5A, 8'h11, 8'h5A, 1'b1, 1'b0},
    {3'b001, 8'h20, 8'hC3, 8'hE7, 8'hC3, 1'b0, 1'b0},
    {3'b010, 8'h20, 8'h77, 8'h08, 8'hC3, 1'b1, 1'b0},
    {3'b011, 8'h00, 8'h99, 8'h42, 8'hC3, 1'b1, 1'b1},
    {3'b011, 8'h20, 8'h44, 8'h81, 8'hC3, 1'b0, 1'b0},
    {3'b100, 8'h20, 8'h12, 8'hF0, 8'hC3, 1'b0, 1'b0},
    {3'b111, 8'h00, 8'h34, 8'h0F, 8'hC3, 1'b1, 1'b0},
    {3'b000, 8'h00, 8'hFF, 8'h55, 8'hFF, 1'b1, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] portMode = 3'b000;
  logic [2:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0, pinDataIn = '0;
  logic prnFaultN = 1'b1, prnSelect = 1'b0, prnPaperErr = 1'b0, prnAckN = 1'b1, prnBusy = 1'b0;
  logic fifoReady = 1'b1;
  logic [7:0] busRdata, pinDataOut, fifoData;
  logic pinDataOe, ctlStrobeN, ctlAutoFdN, ctlInitN, ctlSelInN, ackIrq, fifoValid, fifoTag;

  int checks = 0;
  int failures = 0;
  logic pushSeen;
  logic [7:0] pushData;
  logic pushTag;
  logic [7:0] rd;

  always #(PERIOD/2) clk = ~clk;

  prnPortRegs u_prnPortRegs (
    .clk(clk), .rstN(rstN), .portMode(portMode), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata),
    .pinDataIn(pinDataIn), .pinDataOut(pinDataOut), .pinDataOe(pinDataOe),
    .prnFaultN(prnFaultN), .prnSelect(prnSelect), .prnPaperErr(prnPaperErr),
    .prnAckN(prnAckN), .prnBusy(prnBusy), .ctlStrobeN(ctlStrobeN),
    .ctlAutoFdN(ctlAutoFdN), .ctlInitN(ctlInitN), .ctlSelInN(ctlSelInN),
    .ackIrq(ackIrq), .fifoValid(fifoValid), .fifoReady(fifoReady),
    .fifoData(fifoData), .fifoTag(fifoTag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    #(PERIOD/4);
    pushSeen = fifoValid; pushData = fifoData; pushTag = fifoTag;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    d = busRdata;
    busRd = 1'b0;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cycles(2);
    // R1 reset state
    check("R1 pinDataOut", pinDataOut, 8'h00);
    check("R1 strobeN", ctlStrobeN, 1);
    check("R1 autoFdN", ctlAutoFdN, 1);
    check("R1 initN", ctlInitN, 0);
    check("R1 selInN", ctlSelInN, 1);
    check("R1 oe", pinDataOe, 1);
    check("R1 irq", ackIrq, 0);
    check("R1 rdata", busRdata, 8'h00);
    rstN = 1'b1;
    cycles(1);
    busRead(3'd2, rd);
    check("R1 ctrl after reset", rd, 8'h00);

    // Table: R2 R3 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      logic [36:0] e;
      e = VEC[v];
      portMode = e[36:34];
      busWrite(3'd2, e[33:26]);
      busWrite(3'd0, e[25:18]);
      check("R8 push strobe", pushSeen, e[0]);
      if (e[0]) begin
        check("R8 push data", pushData, e[25:18]);
        check("R8 push tag", pushTag, 1);
      end
      pinDataIn = e[17:10];
      check("R2 latch out", pinDataOut, e[9:2]);
      check("R7 oe", pinDataOe, e[1]);
      busRead(3'd0, rd);
      check("R3 pin readback", rd, e[17:10]);
    end

    // R11 idle after a read and unmapped offsets
    cycles(1);
    check("R11 idle rdata", busRdata, 8'h00);
    busRead(3'd3, rd);
    check("R11 offset 3", rd, 8'h00);
    busRead(3'd7, rd);
    check("R11 offset 7", rd, 8'h00);

    // R4 status layout
    prnFaultN = 1; prnSelect = 0; prnPaperErr = 1; prnAckN = 0; prnBusy = 1;
    busRead(3'd1, rd);
    check("R4 status pattern A", rd, 8'h28);
    prnFaultN = 0; prnSelect = 1; prnPaperErr = 0; prnAckN = 1; prnBusy = 0;
    busRead(3'd1, rd);
    check("R4 status pattern B", rd, 8'hD0);

    // R5 / R6 control
    portMode = 3'b000;
    busWrite(3'd2, 8'hFF);
    busRead(3'd2, rd);
    check("R5 ctrl top bits", rd, 8'h3F);
    check("R6 strobeN", ctlStrobeN, 0);
    check("R6 autoFdN", ctlAutoFdN, 0);
    check("R6 initN", ctlInitN, 1);
    check("R6 selInN", ctlSelInN, 0);
    busWrite(3'd2, 8'h05);
    check("R6 strobeN b", ctlStrobeN, 0);
    check("R6 autoFdN b", ctlAutoFdN, 1);
    check("R6 initN b", ctlInitN, 1);
    check("R6 selInN b", ctlSelInN, 1);

    // R12 push dropped when not ready
    portMode = 3'b011;
    busWrite(3'd2, 8'h00);
    fifoReady = 1'b0;
    busWrite(3'd0, 8'h66);
    check("R12 no valid during", pushSeen, 0);
    check("R12 no valid after", fifoValid, 0);
    cycles(2);
    check("R12 still idle", fifoValid, 0);
    fifoReady = 1'b1;

    // R9 enabled edge latency
    portMode = 3'b000;
    busWrite(3'd2, 8'h10);
    prnAckN = 0; cycles(4);
    prnAckN = 1;
    cycles(2);
    check("R9 irq not yet", ackIrq, 0);
    cycles(1);
    check("R9 irq set", ackIrq, 1);

    // R10 clear by status read
    busRead(3'd1, rd);
    check("R10 cleared by status read", ackIrq, 0);

    // R10 clear by enable drop
    prnAckN = 0; cycles(4);
    prnAckN = 1; cycles(4);
    check("R9 irq set again", ackIrq, 1);
    busWrite(3'd2, 8'h00);
    cycles(1);
    check("R10 cleared by enable", ackIrq, 0);

    // R9 disabled edge ignored
    prnAckN = 0; cycles(4);
    prnAckN = 1; cycles(5);
    check("R9 disabled no irq", ackIrq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule